// File: doc/BRIEF.md
# Prescaler plus programmable clock divider

This block derives a slower clock from a master clock. The master clock first passes through a prescaler that divides by 1, 2 or 4. A 9-bit programmable divider then follows, with a divisor equal to its code plus two. A mode word holds three control bits that override one another in layers. The full-bypass bit sends the master clock straight to the output. The prescaler-bypass bit removes only the prescaler. The ratio bit picks a prescale of 2 or 4. The output is a divided clock with a low phase that is never shorter than its high phase.

The configuration is not live. Both words are captured only on a load strobe, and a mode word whose fixed bits are wrong is refused. An accepted load restarts the waveform from the start of a low phase. An enable input holds the output low and parks the counters. After reset the block divides by 2 until it is loaded.

Top module: `prescale_divider`

## Requirements
- R1: While reset is asserted and after it is released, the output starts low, and the default configuration gives a total ratio of 2. That default is the prescaler bypassed with divide code 0.
- R2: With the prescaler bypassed (mode bit 2 = 1, mode bit 1 = 0), the total ratio is the divide code plus 2. Codes 0 to 511 give ratios 2 to 513.
- R3: With mode bits 1, 2 and 3 all 0, the prescale is 4 and the total ratio is 4·(code+2).
- R4: With mode bits 1 and 2 at 0 and mode bit 3 at 1, the prescale is 2 and the total ratio is 2·(code+2).
- R5: With mode bit 1 = 1 the output follows the master clock while enabled. Mode bits 2 and 3 and the divide code have no effect.
- R6: A load is accepted only when mode bits 8..4 equal 00011 and mode bit 0 is 0. Any other mode word leaves the configuration and the waveform phase unchanged.
- R7: Changes on the configuration inputs without a load strobe have no effect on the output.
- R8: An accepted load (sampled with enable high) takes effect at that clock edge. It drives the output low and starts a new period from its beginning.
- R9: For a total ratio R ≥ 2, each period is ceil(R/2) master cycles low followed by floor(R/2) cycles high. Even ratios therefore give an exact 50% duty.
- R10: While enable is low the output is low at once and the counters are cleared. After enable returns, the first rising edge of the output comes after a full low phase of ceil(R/2) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Output enable; low holds the output low and clears the counters |
| load_i | input | 1 | Strobe that captures the two configuration words |
| mode_i | input | 9 | Mode word: bit 3 ratio select, bit 2 prescaler bypass, bit 1 full bypass, fixed bits 8..4 = 00011 and bit 0 = 0 |
| div_i | input | 9 | Divide code; divisor = code + 2 |
| clk_o | output | 1 | Divided clock |

## Verification
The hardest condition to reach from the ports is a refused load that lands in the middle of a period. The bench has to show that the phase carries on across that strobe, not just that the final ratio is correct. The stimulus does this by issuing bad mode words at random points inside running periods. The reference phase counter keeps advancing through those strobes, so any spurious restart or configuration change shows up as a phase mismatch. The largest ratio, 2052, is run over two full periods, which exercises the wrap of both counters at their top codes.

// File: rtl/prescale_divider_pkg.sv
package prescale_divider_pkg;

    localparam int CODE_W   = 9;
    localparam int MODE_W   = 9;
    localparam int PRE_LOG2 = 2;
    localparam int DCNT_W   = CODE_W + 1;
    localparam int TOT_W    = CODE_W + 1 + PRE_LOG2;

    localparam logic [4:0] MODE_FIXED_HI = 5'b00011;
    localparam logic       MODE_FIXED_LO = 1'b0;

    typedef struct packed {
        logic              pass_all;
        logic              skip_pre;
        logic              half_pre;
        logic [CODE_W-1:0] code;
    } div_cfg_t;

    localparam div_cfg_t CFG_RESET = '{pass_all: 1'b0, skip_pre: 1'b1,
                                       half_pre: 1'b0, code: '0};

    function automatic logic mode_ok(input logic [MODE_W-1:0] w);
        return (w[8:4] == MODE_FIXED_HI) && (w[0] == MODE_FIXED_LO);
    endfunction

    function automatic logic [1:0] pre_shift(input div_cfg_t c);
        if (c.skip_pre) return 2'd0;
        else if (c.half_pre) return 2'd1;
        else return 2'd2;
    endfunction

endpackage

// File: rtl/pd_cfg_latch.sv
module pd_cfg_latch
    import prescale_divider_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [CODE_W-1:0] div_i,
    output div_cfg_t          cfg_o,
    output logic              accept_o
);

    typedef struct packed {
        div_cfg_t cfg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept_o = load_i && mode_ok(mode_i);
        if (accept_o) begin
            st_d.cfg.pass_all = mode_i[1];
            st_d.cfg.skip_pre = mode_i[2];
            st_d.cfg.half_pre = mode_i[3];
            st_d.cfg.code     = div_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cfg: CFG_RESET};
        else         st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;

endmodule

// File: rtl/pd_prescale_cnt.sv
module pd_prescale_cnt #(
    parameter int LOG2_MAX = 2,
    localparam int CW = (LOG2_MAX > 0) ? LOG2_MAX : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [1:0]    shift_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] last;

    generate
        if (LOG2_MAX > 0) begin : g_pre
            assign last = CW'((32'd1 << shift_i) - 32'd1);
        end else begin : g_nopre
            assign last = '0;
        end
    endgenerate

    always_comb begin
        st_d   = st_q;
        wrap_o = run_i && !clear_i && (st_q.cnt == last);
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (run_i) begin
            st_d.cnt = (st_q.cnt == last) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/pd_divide_cnt.sv
module pd_divide_cnt #(
    parameter int W = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         tick_i,
    input  logic [W-1:0] last_i,
    output logic [W-1:0] cnt_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = (st_q.cnt == last_i) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/prescale_divider.sv
module prescale_divider
    import prescale_divider_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              load_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [CODE_W-1:0] div_i,
    output logic              clk_o
);

    localparam int PW = (PRE_LOG2 > 0) ? PRE_LOG2 : 1;

    div_cfg_t          cfg_q;
    logic              accept;
    logic [1:0]        shift;
    logic [PW-1:0]     pre_cnt;
    logic              pre_wrap;
    logic [DCNT_W-1:0] div_cnt;
    logic [DCNT_W-1:0] div_last;
    logic [TOT_W-1:0]  ratio;
    logic [TOT_W-1:0]  low_len;
    logic [TOT_W-1:0]  pos;
    logic              clear;
    logic              run;

    typedef struct packed {
        logic wave;
    } st_t;

    st_t st_d, st_q;
    logic wave_q;

    pd_cfg_latch u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load_i),
        .mode_i   (mode_i),
        .div_i    (div_i),
        .cfg_o    (cfg_q),
        .accept_o (accept)
    );

    assign shift    = pre_shift(cfg_q);
    assign clear    = !en_i || accept;
    assign run      = en_i && !accept && !cfg_q.pass_all;
    assign div_last = {1'b0, cfg_q.code} + 1'b1;

    pd_prescale_cnt #(.LOG2_MAX(PRE_LOG2)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear),
        .run_i   (run),
        .shift_i (shift),
        .cnt_o   (pre_cnt),
        .wrap_o  (pre_wrap)
    );

    pd_divide_cnt #(.W(DCNT_W)) u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear),
        .tick_i  (pre_wrap),
        .last_i  (div_last),
        .cnt_o   (div_cnt)
    );

    assign ratio   = TOT_W'({1'b0, cfg_q.code} + 2'd2) << shift;
    assign low_len = ratio - (ratio >> 1);
    assign pos     = (TOT_W'(div_cnt) << shift) | TOT_W'(pre_cnt);

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.wave = 1'b0;
        end else if (run) begin
            st_d.wave = (pos >= low_len);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign wave_q = st_q.wave;
    assign clk_o  = en_i && (cfg_q.pass_all ? clk_i : wave_q);

endmodule

// File: rtl/prescale_divider_chk.sv
module prescale_divider_chk
    import prescale_divider_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              load_i,
    input logic [MODE_W-1:0] mode_i,
    input div_cfg_t          cfg_q,
    input logic [1:0]        pre_cnt,
    input logic [DCNT_W-1:0] div_cnt,
    input logic              wave_q
);

    // R10: disabled output parks every counter and the waveform
    a_r10_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (pre_cnt == '0 && div_cnt == '0 && !wave_q));

    // R6: a refused mode word leaves the configuration alone
    a_r6_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !mode_ok(mode_i)) |=> $stable(cfg_q));

    // R7: no strobe, no change
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(cfg_q));

    // R8: accepted load restarts the period
    a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && load_i && mode_ok(mode_i)) |=>
            (!wave_q && pre_cnt == '0 && div_cnt == '0));

    // R2: divider never passes its last code
    a_r2_div_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_cnt <= ({1'b0, cfg_q.code} + 1'b1));

    // R2: bypassed prescaler stays at zero
    a_r2_pre_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.skip_pre && !cfg_q.pass_all) |-> (pre_cnt == '0));

    // R4: prescale of two uses only codes 0 and 1
    a_r4_pre_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_q.skip_pre && cfg_q.half_pre) |-> (pre_cnt <= 2'd1));

endmodule

bind prescale_divider prescale_divider_chk chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .load_i  (load_i),
    .mode_i  (mode_i),
    .cfg_q   (cfg_q),
    .pre_cnt (pre_cnt),
    .div_cnt (div_cnt),
    .wave_q  (wave_q)
);

// File: tb/prescale_divider_tb_top.sv
`timescale 1ns/1ps
module prescale_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       load = 1'b0;
    logic [8:0] mode;
    logic [8:0] divw = '0;
    logic       clk_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int  ratio = 2;
    int  k = 0;
    bit  bypass = 1'b0;

    always #10 clk = ~clk;

    prescale_divider dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .en_i   (en),
        .load_i (load),
        .mode_i (mode),
        .div_i  (divw),
        .clk_o  (clk_out)
    );

    function automatic logic [8:0] mk_mode(bit all, bit skip, bit half);
        return {5'b00011, half, skip, all, 1'b0};
    endfunction

    function automatic bit word_ok(logic [8:0] w);
        return (w[8:4] == 5'b00011) && !w[0];
    endfunction

    function automatic int calc_ratio(logic [8:0] w, logic [8:0] c);
        if (w[1]) return 1;
        if (w[2]) return int'(c) + 2;
        if (w[3]) return 2 * (int'(c) + 2);
        return 4 * (int'(c) + 2);
    endfunction

    function automatic bit exp_wave(int r, int kk);
        return ((kk - 1) % r) >= (r - r / 2);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (ratio=%0d k=%0d)", tag, act, exp, ratio, k);
        end
    endtask

    task automatic tick(string tag);
        if (bypass) begin
            @(posedge clk); #5;
            chk(clk_out == 1'b1, tag, clk_out, 1);
            #10;
            chk(clk_out == 1'b0, tag, clk_out, 0);
        end else begin
            @(posedge clk); #15;
            k++;
            chk(clk_out == exp_wave(ratio, k), tag, clk_out, exp_wave(ratio, k));
        end
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    // called at posedge+15; the strobe is captured at the next edge
    task automatic do_load(logic [8:0] w, logic [8:0] c);
        bit ok;
        ok = word_ok(w);
        mode = w; divw = c; load = 1'b1;
        @(posedge clk); #15;
        load = 1'b0;
        if (ok) begin
            ratio  = calc_ratio(w, c);
            bypass = w[1];
            k = 0;
            if (!bypass) chk(clk_out == 1'b0, "R8 restart low", clk_out, 0);
        end else if (!bypass) begin
            k++;
            chk(clk_out == exp_wave(ratio, k), "R6 phase kept", clk_out, exp_wave(ratio, k));
        end
    endtask

    task automatic load_run(logic [8:0] w, logic [8:0] c, string tag);
        do_load(w, c);
        if (bypass) ticks(6, tag);
        else ticks(2 * ratio + 3, tag);
    endtask

    task automatic enable_cycle(string tag);
        en = 1'b0; #1;
        chk(clk_out == 1'b0, tag, clk_out, 0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #5;
            chk(clk_out == 1'b0, tag, clk_out, 0);
            #10;
        end
        en = 1'b1;
        k = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        mode = mk_mode(0, 1, 0);
        repeat (3) @(posedge clk);
        #15;
        chk(clk_out == 1'b0, "R1 reset low", clk_out, 0);
        rst_n = 1'b1; en = 1'b1;
        ratio = 2; k = 0;
        ticks(6, "R1 default ratio 2");

        // R7: inputs move with no strobe
        mode = mk_mode(1, 0, 0); divw = 9'd37;
        ticks(6, "R7 no strobe");

        load_run(mk_mode(0, 1, 0), 9'd5, "R9 odd ratio 7");
        load_run(mk_mode(0, 0, 1), 9'd3, "R4 prescale 2");
        load_run(mk_mode(0, 0, 0), 9'd2, "R3 prescale 4");

        // R6: bad fixed bits mid-period
        ticks(5, "R3 prescale 4");
        do_load(mk_mode(0, 1, 0) | 9'h001, 9'd0);
        ticks(7, "R6 low bit set");
        do_load({5'b10011, 4'b0100}, 9'd1);
        ticks(20, "R6 high bits wrong");

        // R10: enable drop during a divided run
        ticks(3, "R3 prescale 4");
        enable_cycle("R10 held low");
        ticks(2 * ratio, "R10 full low phase after enable");

        // R5: full bypass ignores the other fields
        load_run(mk_mode(1, 0, 0), 9'd99, "R5 bypass");
        load_run(mk_mode(1, 1, 1), 9'd511, "R5 bypass other fields");
        enable_cycle("R10 bypass held low");
        ticks(3, "R5 bypass after enable");

        load_run(mk_mode(0, 1, 0), 9'd511, "R2 ratio 513");
        load_run(mk_mode(0, 1, 0), 9'd0, "R2 ratio 2");
        load_run(mk_mode(0, 0, 0), 9'd0, "R3 ratio 8");
        load_run(mk_mode(0, 0, 0), 9'd511, "R3 ratio 2052");

        for (int it = 0; it < 25; it++) begin
            int sel;
            logic [8:0] w;
            sel = int'($urandom % 8);
            w = mk_mode(sel == 0, sel[0], sel[1]);
            load_run(w, 9'($urandom % 64), "R9 random");
            if (!bypass && ($urandom % 2) == 1) begin
                ticks(int'($urandom % 9), "R9 random");
                do_load(9'($urandom) | 9'h001, 9'($urandom));
                ticks(ratio + 2, "R6 random reject");
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule